// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block runs sixteen general-purpose pins, grouped into two banks of eight, behind a byte-wide register port. Pin `p` sits in bank `p / 8` at bit `p % 8`. Each pin has two bytes of its own:

- An output-control byte sets direction, drive type, pull enable, pull selection and the driven value.
- An input-control byte reports the pin level and selects which input edges raise an interrupt.

Every input passes through a two-stage synchronizer. A detected edge that matches the pin's mode sets a pending bit in that pin's bank. Software clears a pending bit by writing a one to it. Each bank also has a mask byte. The single interrupt output is high while any pending bit has its mask bit clear.

Host access is a simple synchronous port. A write takes effect on the clock edge where the write strobe is high. Read data appears on the clock edge after the read strobe and holds until the next read.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe_o` = 0), every edge mode is 0, both interrupt mask bytes and both sleep mask bytes read 0xFF, both pending bytes read 0x00, and `irq_o` is low.
- R2: The output-control byte of pin `p` is at 0x2B+p for p<8 and at 0x3B+(p-8) for p≥8. The input-control byte is at 0x33+p or 0x43+(p-8). Read data appears on the clock edge after `reg_re_i` is sampled high. Any address outside 0x0B–0x0C, 0x19–0x1C and 0x2B–0x4A reads as 0x00.
- R3: The output-control fields are:
  - bit 5: direction (1 = output)
  - bit 4: open-drain (1 = open-drain)
  - bit 3: pull enable, driven on `pull_en_o[p]`
  - bits 2:1: pull select, driven on `pull_sel_o[2p+1:2p]`
  - bit 0: output value
  
  Bits 7:6 read as 0. In push-pull output mode `pin_oe_o[p]` = 1 and `pin_o[p]` = bit 0. An input pin has `pin_oe_o[p]` = 0.
- R4: For a pin in open-drain output mode, value 0 gives `pin_oe_o` = 1 with `pin_o` = 0, and value 1 gives `pin_oe_o` = 0. `pin_o` is 0 whenever open-drain is selected.
- R5: Input-control bit 0 returns the synchronized level of `pin_i[p]`, whatever the pin's direction. A change on `pin_i` becomes readable two clock edges later. Writes to bit 0 are ignored.
- R6: Input-control bits 2:1 select the edge mode: 0 no detection, 1 falling edge, 2 rising edge, 3 both edges. A matching edge sets the pending bit on the third clock edge after `pin_i` changes.
- R7: The pending bytes are at 0x0B (bank 0) and 0x0C (bank 1), with bit `p % 8` for pin `p`. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R8: If a detected edge and a write-1 clear hit the same pending bit on the same clock edge, the bit stays set.
- R9: The interrupt mask bytes are at 0x19 (bank 0) and 0x1A (bank 1), where a 1 masks the pin. `irq_o` equals the OR over all pins of pending AND NOT mask. It changes in the same cycle as the registers that feed it.
- R10: The sleep mask bytes at 0x1B and 0x1C are read/write storage and have no effect on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| pin_i | input | 16 | Pin input levels, asynchronous |
| pin_o | output | 16 | Pin output values |
| pin_oe_o | output | 16 | Pin output enables |
| pull_en_o | output | 16 | Pull resistor enables |
| pull_sel_o | output | 32 | Pull selection, two bits per pin |
| irq_o | output | 1 | Combined interrupt, level |

## Verification
The results fall due at different clock edges:
- A write shows on the pin controls and the mask-driven interrupt one clock edge after the strobe.
- Read data shows one clock edge after the read strobe.
- A pin change becomes readable after two edges and sets its pending bit and the interrupt after three.

The bench drives inputs on the falling edge and advances a behavioural model on each rising edge, using the same sampled inputs as the design. It compares every output against the model on the next falling edge, so each result is checked in exactly the cycle it falls due. Directed sequences add fixed expected values at those edges. This includes an edge-versus-clear collision timed so that the write lands on the third edge after the pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned NUM_BANKS = 2;
  localparam int unsigned BANK_W    = 8;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned DATA_W    = 8;

  localparam logic [ADDR_W-1:0] CTLO_BASE   = 8'h2B;
  localparam logic [ADDR_W-1:0] CTLI_BASE   = 8'h33;
  localparam logic [ADDR_W-1:0] BANK_STRIDE = 8'h10;
  localparam logic [ADDR_W-1:0] PEND_BASE   = 8'h0B;
  localparam logic [ADDR_W-1:0] MASK_BASE   = 8'h19;
  localparam logic [ADDR_W-1:0] SMASK_BASE  = 8'h1B;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o  = sync_q;
  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank import gpio_irq_pkg::*; #(
  parameter int unsigned BANK_W   = 8,
  parameter int unsigned BANK_IDX = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [BANK_W-1:0]   lvl_i,
  input  logic [BANK_W-1:0]   rise_i,
  input  logic [BANK_W-1:0]   fall_i,
  output logic [BANK_W-1:0]   dir_o,
  output logic [BANK_W-1:0]   od_o,
  output logic [BANK_W-1:0]   val_o,
  output logic [BANK_W-1:0]   pull_en_o,
  output logic [2*BANK_W-1:0] pull_sel_o,
  output logic [BANK_W-1:0]   pend_o,
  output logic [BANK_W-1:0]   mask_o,
  output logic [BANK_W-1:0]   edge_hit_o,
  output logic [DATA_W-1:0]   rdata_o
);
  localparam int unsigned IDX_W = $clog2(BANK_W);
  localparam logic [ADDR_W-1:0] BW_A = ADDR_W'(BANK_W);
  localparam logic [ADDR_W-1:0] BI_A = ADDR_W'(BANK_IDX);
  localparam logic [ADDR_W-1:0] OB   = CTLO_BASE + BI_A * BANK_STRIDE;
  localparam logic [ADDR_W-1:0] IB   = CTLI_BASE + BI_A * BANK_STRIDE;
  localparam logic [ADDR_W-1:0] PB   = PEND_BASE + BI_A;
  localparam logic [ADDR_W-1:0] MB   = MASK_BASE + BI_A;
  localparam logic [ADDR_W-1:0] SB   = SMASK_BASE + BI_A;

  logic [5:0]        ctlo_q [BANK_W];
  edge_mode_e        mode_q [BANK_W];
  logic [BANK_W-1:0] pend_q, mask_q, smask_q;

  logic [ADDR_W-1:0] o_off, i_off;
  logic [IDX_W-1:0]  o_idx, i_idx;
  logic              o_hit, i_hit, p_hit, m_hit, s_hit;
  logic [BANK_W-1:0] clr;

  assign o_off = addr_i - OB;
  assign i_off = addr_i - IB;
  assign o_idx = o_off[IDX_W-1:0];
  assign i_idx = i_off[IDX_W-1:0];
  assign o_hit = o_off < BW_A;
  assign i_hit = i_off < BW_A;
  assign p_hit = addr_i == PB;
  assign m_hit = addr_i == MB;
  assign s_hit = addr_i == SB;
  assign clr   = (we_i && p_hit) ? wdata_i[BANK_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < BANK_W; p++) begin
        ctlo_q[p] <= '0;
        mode_q[p] <= EDGE_OFF;
      end
      pend_q  <= '0;
      mask_q  <= '1;
      smask_q <= '1;
    end else begin
      if (we_i && o_hit) ctlo_q[o_idx] <= wdata_i[5:0];
      if (we_i && i_hit) mode_q[i_idx] <= edge_mode_e'(wdata_i[2:1]);
      if (we_i && m_hit) mask_q  <= wdata_i[BANK_W-1:0];
      if (we_i && s_hit) smask_q <= wdata_i[BANK_W-1:0];
      // set beats clear on collision
      pend_q <= (pend_q & ~clr) | edge_hit_o;
    end
  end

  for (genvar p = 0; p < BANK_W; p++) begin : g_pin
    assign dir_o[p]            = ctlo_q[p][5];
    assign od_o[p]             = ctlo_q[p][4];
    assign pull_en_o[p]        = ctlo_q[p][3];
    assign pull_sel_o[2*p +: 2] = ctlo_q[p][2:1];
    assign val_o[p]            = ctlo_q[p][0];
    assign edge_hit_o[p]       = (fall_i[p] & mode_q[p][0]) | (rise_i[p] & mode_q[p][1]);
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    if (o_hit)      rdata_o = {2'b00, ctlo_q[o_idx]};
    else if (i_hit) rdata_o = {5'b00000, mode_q[i_idx], lvl_i[i_idx]};
    else if (p_hit) rdata_o = DATA_W'(pend_q);
    else if (m_hit) rdata_o = DATA_W'(mask_q);
    else if (s_hit) rdata_o = DATA_W'(smask_q);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl import gpio_irq_pkg::*; #(
  parameter int unsigned NUM_BANKS = gpio_irq_pkg::NUM_BANKS,
  parameter int unsigned BANK_W    = gpio_irq_pkg::BANK_W,
  localparam int unsigned NUM_PINS = NUM_BANKS * BANK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  reg_we_i,
  input  logic                  reg_re_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   pin_o,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [NUM_PINS-1:0]   pull_en_o,
  output logic [2*NUM_PINS-1:0] pull_sel_o,
  output logic                  irq_o
);
  logic [NUM_PINS-1:0] lvl, rise, fall;
  logic [NUM_PINS-1:0] dir_q, od_q, val_q, pend_q, mask_q, edge_hit;
  logic [DATA_W-1:0]   bank_rdata [NUM_BANKS];
  logic [DATA_W-1:0]   rd_mux, rdata_q;

  gpio_edge_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank #(.BANK_W(BANK_W), .BANK_IDX(b)) u_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (reg_we_i),
      .addr_i     (reg_addr_i),
      .wdata_i    (reg_wdata_i),
      .lvl_i      (lvl[b*BANK_W +: BANK_W]),
      .rise_i     (rise[b*BANK_W +: BANK_W]),
      .fall_i     (fall[b*BANK_W +: BANK_W]),
      .dir_o      (dir_q[b*BANK_W +: BANK_W]),
      .od_o       (od_q[b*BANK_W +: BANK_W]),
      .val_o      (val_q[b*BANK_W +: BANK_W]),
      .pull_en_o  (pull_en_o[b*BANK_W +: BANK_W]),
      .pull_sel_o (pull_sel_o[2*b*BANK_W +: 2*BANK_W]),
      .pend_o     (pend_q[b*BANK_W +: BANK_W]),
      .mask_o     (mask_q[b*BANK_W +: BANK_W]),
      .edge_hit_o (edge_hit[b*BANK_W +: BANK_W]),
      .rdata_o    (bank_rdata[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) rd_mux |= bank_rdata[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  // open-drain: drive only a low
  assign pin_oe_o    = dir_q & ~(od_q & val_q);
  assign pin_o       = val_q & ~od_q;
  assign irq_o       = |(pend_q & ~mask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        reg_re_i,
  input logic [7:0]  reg_addr_i,
  input logic [7:0]  reg_rdata_o,
  input logic        irq_o,
  input logic [15:0] pin_oe_o,
  input logic [15:0] dir_q,
  input logic [15:0] pend_q,
  input logic [15:0] mask_q,
  input logic [15:0] edge_hit,
  input logic [15:0] rise,
  input logic [15:0] fall
);
  function automatic logic mapped(input logic [7:0] a);
    return (a >= 8'h2B && a <= 8'h4A) || (a >= 8'h0B && a <= 8'h0C) ||
           (a >= 8'h19 && a <= 8'h1C);
  endfunction

  assert_unmapped_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && !mapped(reg_addr_i)) |=> (reg_rdata_o == 8'h00));

  assert_oe_needs_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_oe_o & ~dir_q) == 16'h0000));

  assert_pend_from_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q) & ~$past(rise | fall)) == 16'h0000));

  assert_edge_beats_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(edge_hit) & ~pend_q) == 16'h0000));

  assert_masked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~mask_q) == 16'h0000) |-> !irq_o);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_re_i    (reg_re_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_o       (irq_o),
  .pin_oe_o    (pin_oe_o),
  .dir_q       (dir_q),
  .pend_q      (pend_q),
  .mask_q      (mask_q),
  .edge_hit    (edge_hit),
  .rise        (rise),
  .fall        (fall)
);

// File: tb/gpio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = 8'h00, wdata = 8'h00;
  logic [15:0] pin = 16'h0000;
  logic [7:0]  rdata;
  logic [15:0] pin_o, pin_oe, pull_en;
  logic [31:0] pull_sel;
  logic        irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pin_i(pin), .pin_o(pin_o), .pin_oe_o(pin_oe), .pull_en_o(pull_en),
    .pull_sel_o(pull_sel), .irq_o(irq)
  );

  // behavioural reference
  logic [5:0]  m_ctlo [16];
  logic [1:0]  m_mode [16];
  logic [15:0] m_pend, m_mask, m_smask, h1, h2, h3;
  logic [7:0]  m_rdata;

  function automatic logic [7:0] rd_model(input logic [7:0] a);
    int i;
    if (a >= 8'h2B && a <= 8'h32) begin i = int'(a) - 'h2B;     return {2'b0, m_ctlo[i]}; end
    if (a >= 8'h3B && a <= 8'h42) begin i = int'(a) - 'h3B + 8; return {2'b0, m_ctlo[i]}; end
    if (a >= 8'h33 && a <= 8'h3A) begin i = int'(a) - 'h33;     return {5'b0, m_mode[i], h2[i]}; end
    if (a >= 8'h43 && a <= 8'h4A) begin i = int'(a) - 'h43 + 8; return {5'b0, m_mode[i], h2[i]}; end
    case (a)
      8'h0B: return m_pend[7:0];
      8'h0C: return m_pend[15:8];
      8'h19: return m_mask[7:0];
      8'h1A: return m_mask[15:8];
      8'h1B: return m_smask[7:0];
      8'h1C: return m_smask[15:8];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_ctlo[i] = '0; m_mode[i] = '0; end
      m_pend = '0; m_mask = '1; m_smask = '1; h1 = '0; h2 = '0; h3 = '0; m_rdata = '0;
    end else begin
      logic [15:0] ev, clr;
      ev = '0; clr = '0;
      for (int i = 0; i < 16; i++)
        ev[i] = (~h2[i] & h3[i] & m_mode[i][0]) | (h2[i] & ~h3[i] & m_mode[i][1]);
      if (re) m_rdata = rd_model(addr);
      if (we) begin
        if (addr >= 8'h2B && addr <= 8'h32) m_ctlo[int'(addr) - 'h2B] = wdata[5:0];
        if (addr >= 8'h3B && addr <= 8'h42) m_ctlo[int'(addr) - 'h3B + 8] = wdata[5:0];
        if (addr >= 8'h33 && addr <= 8'h3A) m_mode[int'(addr) - 'h33] = wdata[2:1];
        if (addr >= 8'h43 && addr <= 8'h4A) m_mode[int'(addr) - 'h43 + 8] = wdata[2:1];
        case (addr)
          8'h0B: clr[7:0] = wdata;
          8'h0C: clr[15:8] = wdata;
          8'h19: m_mask[7:0] = wdata;
          8'h1A: m_mask[15:8] = wdata;
          8'h1B: m_smask[7:0] = wdata;
          8'h1C: m_smask[15:8] = wdata;
          default: ;
        endcase
      end
      m_pend = (m_pend & ~clr) | ev;
      h3 = h2; h2 = h1; h1 = pin;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) if (rst_n) begin
    logic [15:0] e_oe, e_o, e_pe;
    logic [31:0] e_ps;
    for (int i = 0; i < 16; i++) begin
      e_oe[i] = m_ctlo[i][5] & ~(m_ctlo[i][4] & m_ctlo[i][0]);
      e_o[i]  = m_ctlo[i][0] & ~m_ctlo[i][4];
      e_pe[i] = m_ctlo[i][3];
      e_ps[2*i +: 2] = m_ctlo[i][2:1];
    end
    chk("R9 irq_o model", {31'b0, irq}, {31'b0, |(m_pend & ~m_mask)});
    chk("R3 pin_oe_o model", {16'b0, pin_oe}, {16'b0, e_oe});
    chk("R4 pin_o model", {16'b0, pin_o}, {16'b0, e_o});
    chk("R3 pull_en_o model", {16'b0, pull_en}, {16'b0, e_pe});
    chk("R3 pull_sel_o model", pull_sel, e_ps);
    chk("R2 rdata model", {24'b0, rdata}, {24'b0, m_rdata});
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0;
    chk(tag, {24'b0, rdata}, {24'b0, exp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe after reset", {16'b0, pin_oe}, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    rd_chk(8'h19, 8'hFF, "R1 mask0 reset");
    rd_chk(8'h1A, 8'hFF, "R1 mask1 reset");
    rd_chk(8'h1C, 8'hFF, "R1 smask1 reset");
    rd_chk(8'h0C, 8'h00, "R1 pend1 reset");
    rd_chk(8'h35, 8'h00, "R1 mode reset");
    // R3 / R4 output control
    wr(8'h2B, 8'h21);
    chk("R3 push-pull oe", {31'b0, pin_oe[0]}, 32'h1);
    chk("R3 push-pull value", {31'b0, pin_o[0]}, 32'h1);
    wr(8'h2C, 8'h30);
    chk("R4 od low oe", {31'b0, pin_oe[1]}, 32'h1);
    chk("R4 od low value", {31'b0, pin_o[1]}, 32'h0);
    wr(8'h2C, 8'h31);
    chk("R4 od release", {31'b0, pin_oe[1]}, 32'h0);
    wr(8'h3D, 8'hFF);
    rd_chk(8'h3D, 8'h3F, "R3 upper bits zero");
    chk("R3 pull enable", {31'b0, pull_en[10]}, 32'h1);
    chk("R3 pull select", {30'b0, pull_sel[21:20]}, 32'h3);
    chk("R4 od high no drive", {31'b0, pin_oe[10]}, 32'h0);
    chk("R4 od pin_o zero", {31'b0, pin_o[10]}, 32'h0);
    // R2 unmapped
    rd_chk(8'h00, 8'h00, "R2 unmapped 00");
    rd_chk(8'h2A, 8'h00, "R2 unmapped 2A");
    rd_chk(8'h4B, 8'h00, "R2 unmapped 4B");
    rd_chk(8'hFF, 8'h00, "R2 unmapped FF");
    // R5 level readback
    @(negedge clk); pin = 16'h8105;
    repeat (3) @(negedge clk);
    rd_chk(8'h33, 8'h01, "R5 level on output pin");
    rd_chk(8'h35, 8'h01, "R5 level pin2");
    rd_chk(8'h43, 8'h01, "R5 level pin8");
    rd_chk(8'h4A, 8'h01, "R5 level pin15");
    wr(8'h35, 8'h00);
    rd_chk(8'h35, 8'h01, "R5 bit0 write ignored high");
    wr(8'h36, 8'h01);
    rd_chk(8'h36, 8'h00, "R5 bit0 write ignored low");
    // R6 edge modes
    wr(8'h36, 8'h04);
    wr(8'h44, 8'h02);
    wr(8'h47, 8'h06);
    wr(8'h38, 8'h00);
    rd_chk(8'h36, 8'h04, "R6 mode readback");
    @(negedge clk); pin = 16'h932D;
    repeat (4) @(negedge clk);
    rd_chk(8'h0B, 8'h08, "R6 rising sets pin3");
    rd_chk(8'h0C, 8'h10, "R6 both sets pin12, falling ignores rise");
    chk("R9 all masked", {31'b0, irq}, 32'h0);
    @(negedge clk); pin = 16'h8105;
    repeat (4) @(negedge clk);
    rd_chk(8'h0B, 8'h08, "R6 rising ignores fall");
    rd_chk(8'h0C, 8'h12, "R6 falling sets pin9");
    // R9 mask
    wr(8'h1A, 8'hEF);
    chk("R9 unmasked pending", {31'b0, irq}, 32'h1);
    // R7 clear
    wr(8'h0C, 8'h00);
    rd_chk(8'h0C, 8'h12, "R7 zero write keeps");
    wr(8'h0C, 8'h10);
    rd_chk(8'h0C, 8'h02, "R7 one write clears");
    chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);
    wr(8'h0B, 8'h08);
    rd_chk(8'h0B, 8'h00, "R7 bank0 clear");
    // R10 sleep mask
    wr(8'h1C, 8'h00);
    rd_chk(8'h1C, 8'h00, "R10 smask storage");
    chk("R10 smask no irq effect", {31'b0, irq}, 32'h0);
    rd_chk(8'h1A, 8'hEF, "R10 mask untouched");
    // R8 edge vs clear collision on pin12
    @(negedge clk); pin = 16'h9105;
    @(negedge clk);
    wr(8'h0C, 8'h10);
    rd_chk(8'h0C, 8'h12, "R8 edge wins");
    chk("R8 irq held", {31'b0, irq}, 32'h1);
    // random traffic, model checks every cycle
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      pin = 16'($urandom);
      we = ($urandom % 3) == 0;
      re = ($urandom % 2) == 0;
      case ($urandom % 4)
        0: addr = 8'h0B + 8'($urandom % 2);
        1: addr = 8'h19 + 8'($urandom % 4);
        2: addr = 8'h2B + 8'($urandom % 32);
        default: addr = 8'($urandom);
      endcase
      wdata = 8'($urandom);
    end
    @(negedge clk); we = 1'b0; re = 1'b0;
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule